// File: doc/BRIEF.md
# Two-Channel Circular Word DMA with Half-Ring Interrupts

This block moves 32-bit words between a ring of memory words and a serial line carrying two 8-bit bearer channels. It has two engines. The transmit engine reads one word per frame strobe and presents its two low byte lanes as the outgoing channel bytes. The receive engine writes one word per frame strobe, built from the two incoming channel bytes. Each engine walks its own ring. Software sets the first, middle and last word address of each ring, and the pointer wraps from the last address back to the first.

Completing the transfer at the middle address, or at the last address, sets a status bit. Software can then refill or drain the half of the ring that has just finished. If a half finishes again while its status bit is still pending, the matching overrun bit is set, because software has missed a service window. Status bits are write-one-to-clear. The interrupt line is the OR of the masked status bits. One control bit starts and stops both engines, and the current pointer of each engine can be read at any time. Each engine talks to memory through a plain request/acknowledge port.

Top module: `bchan_dma_ring`

## Requirements
- R1: After reset the control enable is 0, status reads 0, `irq` is 0, and neither `rd_req` nor `wr_req` is asserted.
- R2: While enabled and idle, a one-cycle `frame_stb` starts exactly one word transfer on each engine, at that engine's current pointer. The pointer then advances by one on acknowledge.
- R3: A transfer completed at the ring's end address moves the pointer to the ring's start address.
- R4: Completing a transfer at the mid address sets status bit 0 (transmit) or bit 2 (receive). Completing one at the end address sets bit 1 (transmit) or bit 3 (receive).
- R5: On completion of a transmit read, bits 7:0 of the word appear on `tx_b1` and bits 15:8 on `tx_b2`. Both hold until the next completion.
- R6: The receive word written is {16'h0000, rx_b2, rx_b1}, with the bytes sampled in the cycle the strobe is accepted.
- R7: Register 0 bit 0 enables both engines. While it is 0, no request is raised and each current pointer is reloaded from its start address.
- R8: `irq` is 1 exactly when status AND mask (register 1, same bit positions) is nonzero.
- R9: Writing register 2 clears each status bit written as 1. A bit set by an event in the same cycle as its clear stays 1.
- R10: A mid or end event on an engine whose matching status bit is still set sets overrun bit 4 (transmit) or bit 5 (receive).
- R11: A raised request keeps its address until acknowledged. A frame strobe arriving while a transfer is outstanding is ignored.
- R12: The transmit pointer reads at register 6 and the receive pointer at register 10. The transmit start, mid and end addresses are at registers 3, 4 and 5, and the receive ones at registers 7, 8 and 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| frame_stb | input | 1 | One-cycle frame strobe |
| rd_req | output | 1 | Transmit memory read request |
| rd_addr | output | 16 | Transmit memory word address |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | Receive memory write request |
| wr_addr | output | 16 | Receive memory word address |
| wr_data | output | 32 | Write data |
| wr_ack | input | 1 | Write acknowledge |
| rx_b1 | input | 8 | Incoming byte, first channel |
| rx_b2 | input | 8 | Incoming byte, second channel |
| tx_b1 | output | 8 | Outgoing byte, first channel |
| tx_b2 | output | 8 | Outgoing byte, second channel |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions assume that the start, mid and end addresses of a ring are not rewritten while its engine is running. They also assume the mid address lies inside the ring and differs from the end address. The wrap and exclusive-half checks depend on this. The stimulus programs both rings once, before the enable bit is set, and never touches them again. Memory acknowledges arrive either at once or after a stall the bench holds for several cycles, and frame strobes are only issued at negative clock edges.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
  localparam int REG_AW = 4;
  localparam int N_ENG  = 2;
  localparam int ENG_TX = 0;
  localparam int ENG_RX = 1;

  typedef enum logic [REG_AW-1:0] {
    REG_CTRL     = 4'h0,
    REG_MASK     = 4'h1,
    REG_STAT     = 4'h2,
    REG_TX_START = 4'h3,
    REG_TX_MID   = 4'h4,
    REG_TX_END   = 4'h5,
    REG_TX_CUR   = 4'h6,
    REG_RX_START = 4'h7,
    REG_RX_MID   = 4'h8,
    REG_RX_END   = 4'h9,
    REG_RX_CUR   = 4'hA
  } reg_sel_e;
endpackage

// File: rtl/dma_ring_engine.sv
module dma_ring_engine #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          frame_stb,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] mid_addr,
  input  logic [AW-1:0] end_addr,
  input  logic          ack,
  output logic          req,
  output logic [AW-1:0] cur,
  output logic          take,
  output logic          done,
  output logic          hit_mid,
  output logic          hit_end
);
  function automatic logic [AW-1:0] ring_next(input logic [AW-1:0] p,
                                              input logic [AW-1:0] s,
                                              input logic [AW-1:0] e);
    return (p == e) ? s : p + 1'b1;
  endfunction

  logic busy;

  assign req     = busy;
  assign take    = !busy && en && frame_stb;
  assign done    = busy && ack;
  assign hit_mid = done && (cur == mid_addr);
  assign hit_end = done && (cur == end_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cur  <= '0;
    end else if (busy) begin
      if (ack) begin
        busy <= 1'b0;
        cur  <= ring_next(cur, start_addr, end_addr);
      end
    end else if (!en) begin
      cur <= start_addr;
    end else if (frame_stb) begin
      busy <= 1'b1;
    end
  end

  // R11
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> (req && $stable(cur)));
  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_end && $stable(start_addr)) |=> (cur == $past(start_addr)));
  // R7
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !req) |=> !req);
  // R4
  half_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_addr != end_addr) |-> $onehot0({hit_mid, hit_end}));
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
  parameter int NSRC = 2,
  localparam int SW  = 3 * NSRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] hit_mid,
  input  logic [NSRC-1:0] hit_end,
  input  logic            clr_we,
  input  logic [SW-1:0]   clr_bits,
  input  logic [SW-1:0]   mask,
  output logic [SW-1:0]   stat,
  output logic            irq
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic mid_q, end_q, ovr_q, ovr_set;
    assign ovr_set = (hit_mid[g] && mid_q) || (hit_end[g] && end_q);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mid_q <= 1'b0;
        end_q <= 1'b0;
        ovr_q <= 1'b0;
      end else begin
        if (hit_mid[g])                      mid_q <= 1'b1;
        else if (clr_we && clr_bits[2*g])    mid_q <= 1'b0;
        if (hit_end[g])                      end_q <= 1'b1;
        else if (clr_we && clr_bits[2*g+1])  end_q <= 1'b0;
        if (ovr_set)                         ovr_q <= 1'b1;
        else if (clr_we && clr_bits[2*NSRC+g]) ovr_q <= 1'b0;
      end
    end

    assign stat[2*g]      = mid_q;
    assign stat[2*g+1]    = end_q;
    assign stat[2*NSRC+g] = ovr_q;

    // R10
    ovr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_mid[g] && stat[2*g]) |=> stat[2*NSRC+g]);
  end

  assign irq = |(stat & mask);

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((stat & $past(stat)) == $past(stat)));
  // R8
  quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
endmodule

// File: rtl/bchan_dma_ring.sv
module bchan_dma_ring
  import bdr_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              frame_stb,
  output logic              rd_req,
  output logic [AW-1:0]     rd_addr,
  input  logic              rd_ack,
  input  logic [DW-1:0]     rd_data,
  output logic              wr_req,
  output logic [AW-1:0]     wr_addr,
  output logic [DW-1:0]     wr_data,
  input  logic              wr_ack,
  input  logic [LANE_W-1:0] rx_b1,
  input  logic [LANE_W-1:0] rx_b2,
  output logic [LANE_W-1:0] tx_b1,
  output logic [LANE_W-1:0] tx_b2,
  output logic              irq
);
  localparam int SW     = 3 * N_ENG;
  localparam int PAIR_W = 2 * LANE_W;

  logic              ctrl_en;
  logic [SW-1:0]     irq_mask;
  logic [SW-1:0]     stat;
  logic [AW-1:0]     ring_start [N_ENG];
  logic [AW-1:0]     ring_mid   [N_ENG];
  logic [AW-1:0]     ring_end   [N_ENG];
  logic [AW-1:0]     cur        [N_ENG];
  logic [N_ENG-1:0]  req, ack, take, done, hit_mid, hit_end;
  logic [DW-1:0]     rx_word;
  logic              stat_clr_we;
  logic              unused_bits;

  assign unused_bits = ^{rd_data[DW-1:PAIR_W], reg_wdata[DW-1:AW]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en  <= 1'b0;
      irq_mask <= '0;
      for (int i = 0; i < N_ENG; i++) begin
        ring_start[i] <= '0;
        ring_mid[i]   <= '0;
        ring_end[i]   <= '0;
      end
    end else if (reg_we) begin
      case (reg_sel_e'(reg_addr))
        REG_CTRL:     ctrl_en                <= reg_wdata[0];
        REG_MASK:     irq_mask               <= reg_wdata[SW-1:0];
        REG_TX_START: ring_start[ENG_TX]     <= reg_wdata[AW-1:0];
        REG_TX_MID:   ring_mid[ENG_TX]       <= reg_wdata[AW-1:0];
        REG_TX_END:   ring_end[ENG_TX]       <= reg_wdata[AW-1:0];
        REG_RX_START: ring_start[ENG_RX]     <= reg_wdata[AW-1:0];
        REG_RX_MID:   ring_mid[ENG_RX]       <= reg_wdata[AW-1:0];
        REG_RX_END:   ring_end[ENG_RX]       <= reg_wdata[AW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel_e'(reg_addr))
      REG_CTRL:     reg_rdata[0]      = ctrl_en;
      REG_MASK:     reg_rdata[SW-1:0] = irq_mask;
      REG_STAT:     reg_rdata[SW-1:0] = stat;
      REG_TX_START: reg_rdata[AW-1:0] = ring_start[ENG_TX];
      REG_TX_MID:   reg_rdata[AW-1:0] = ring_mid[ENG_TX];
      REG_TX_END:   reg_rdata[AW-1:0] = ring_end[ENG_TX];
      REG_TX_CUR:   reg_rdata[AW-1:0] = cur[ENG_TX];
      REG_RX_START: reg_rdata[AW-1:0] = ring_start[ENG_RX];
      REG_RX_MID:   reg_rdata[AW-1:0] = ring_mid[ENG_RX];
      REG_RX_END:   reg_rdata[AW-1:0] = ring_end[ENG_RX];
      REG_RX_CUR:   reg_rdata[AW-1:0] = cur[ENG_RX];
      default: ;
    endcase
  end

  assign ack[ENG_TX] = rd_ack;
  assign ack[ENG_RX] = wr_ack;

  for (genvar g = 0; g < N_ENG; g++) begin : g_eng
    dma_ring_engine #(.AW(AW)) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (ctrl_en),
      .frame_stb  (frame_stb),
      .start_addr (ring_start[g]),
      .mid_addr   (ring_mid[g]),
      .end_addr   (ring_end[g]),
      .ack        (ack[g]),
      .req        (req[g]),
      .cur        (cur[g]),
      .take       (take[g]),
      .done       (done[g]),
      .hit_mid    (hit_mid[g]),
      .hit_end    (hit_end[g])
    );
  end

  assign rd_req  = req[ENG_TX];
  assign rd_addr = cur[ENG_TX];
  assign wr_req  = req[ENG_RX];
  assign wr_addr = cur[ENG_RX];
  assign wr_data = rx_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_b1   <= '0;
      tx_b2   <= '0;
      rx_word <= '0;
    end else begin
      if (done[ENG_TX]) begin
        tx_b1 <= rd_data[LANE_W-1:0];
        tx_b2 <= rd_data[PAIR_W-1:LANE_W];
      end
      if (take[ENG_RX])
        rx_word <= {{(DW-PAIR_W){1'b0}}, rx_b2, rx_b1};
    end
  end

  assign stat_clr_we = reg_we && (reg_addr == REG_STAT);

  dma_irq_status #(.NSRC(N_ENG)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_mid  (hit_mid),
    .hit_end  (hit_end),
    .clr_we   (stat_clr_we),
    .clr_bits (reg_wdata[SW-1:0]),
    .mask     (irq_mask),
    .stat     (stat),
    .irq      (irq)
  );

  // R5
  lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done[ENG_TX] |=> ($stable(tx_b1) && $stable(tx_b2)));
  // R6
  wr_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> $stable(wr_data));
endmodule

// File: tb/tb_bchan_dma_ring.sv
module tb_bchan_dma_ring;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        frame_stb;
  logic        rd_req, rd_ack, wr_req, wr_ack;
  logic [15:0] rd_addr, wr_addr;
  logic [31:0] rd_data, wr_data;
  logic [7:0]  rx_b1, rx_b2, tx_b1, tx_b2;
  logic        irq;
  logic        stall;

  int checks = 0;
  int fails  = 0;
  logic [15:0] tx_p, rx_p;
  logic [31:0] rx_mem [256];

  always #5 clk = ~clk;

  function automatic logic [31:0] tx_word(input logic [15:0] a);
    return {16'hC3C3, a[7:0] ^ 8'h5A, a[7:0]};
  endfunction

  function automatic logic [15:0] step(input logic [15:0] p, input logic [15:0] s,
                                       input logic [15:0] e);
    if (p == e) return s;
    return p + 16'd1;
  endfunction

  assign rd_data = tx_word(rd_addr);
  assign rd_ack  = rd_req & ~stall;
  assign wr_ack  = wr_req & ~stall;

  always @(posedge clk) if (wr_req && wr_ack) rx_mem[wr_addr[7:0]] <= wr_data;

  bchan_dma_ring dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_stb(frame_stb),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .rx_b1(rx_b1), .rx_b2(rx_b2), .tx_b1(tx_b1), .tx_b2(tx_b2), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // one frame; checks lanes and the written receive word
  task automatic xfer(input logic [7:0] b1, input logic [7:0] b2);
    logic [31:0] w;
    @(negedge clk);
    frame_stb = 1'b1; rx_b1 = b1; rx_b2 = b2;
    @(negedge clk);
    frame_stb = 1'b0;
    @(negedge clk);
    w = tx_word(tx_p);
    chk("R5 tx_b1", {24'h0, tx_b1}, {24'h0, w[7:0]});
    chk("R5 tx_b2", {24'h0, tx_b2}, {24'h0, w[15:8]});
    chk("R6 rx word", rx_mem[rx_p[7:0]], {16'h0, b2, b1});
    tx_p = step(tx_p, 16'h10, 16'h13);
    rx_p = step(rx_p, 16'h40, 16'h43);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 rd_req", {31'h0, rd_req}, 32'h0);
    chk("R1 wr_req", {31'h0, wr_req}, 32'h0);
    rreg(4'h2, d); chk("R1 stat", d, 32'h0);
    rreg(4'h0, d); chk("R1 ctrl", d, 32'h0);
  endtask

  task automatic t_program;
    logic [31:0] d;
    wreg(4'h3, 32'h10); wreg(4'h4, 32'h11); wreg(4'h5, 32'h13);
    wreg(4'h7, 32'h40); wreg(4'h8, 32'h41); wreg(4'h9, 32'h43);
    rreg(4'h5, d);  chk("R12 tx end readback", d, 32'h13);
    rreg(4'h8, d);  chk("R12 rx mid readback", d, 32'h41);
    rreg(4'h6, d);  chk("R12 R7 tx cur at start", d, 32'h10);
    rreg(4'hA, d);  chk("R12 R7 rx cur at start", d, 32'h40);
    tx_p = 16'h10; rx_p = 16'h40;
  endtask

  task automatic t_halves;
    logic [31:0] d;
    wreg(4'h0, 32'h1);
    xfer(8'h01, 8'h81);
    rreg(4'h6, d); chk("R2 tx cur advance", d, 32'h11);
    xfer(8'h02, 8'h82);
    rreg(4'h2, d); chk("R4 mid status", d, 32'h05);
    chk("R8 irq masked off", {31'h0, irq}, 32'h0);
    xfer(8'h03, 8'h83);
    xfer(8'h04, 8'h84);
    rreg(4'h2, d); chk("R4 end status", d, 32'h0F);
    rreg(4'h6, d); chk("R3 tx wrap", d, 32'h10);
    rreg(4'hA, d); chk("R3 rx wrap", d, 32'h40);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wreg(4'h1, 32'h01);
    chk("R8 irq on mask", {31'h0, irq}, 32'h1);
    wreg(4'h2, 32'h0F);
    rreg(4'h2, d); chk("R9 w1c", d, 32'h0);
    chk("R8 irq after clear", {31'h0, irq}, 32'h0);
    wreg(4'h1, 32'h30);
  endtask

  task automatic t_overrun;
    logic [31:0] d;
    for (int i = 0; i < 4; i++) xfer(8'h10 + 8'(i), 8'h90 + 8'(i));
    rreg(4'h2, d); chk("R10 no overrun yet", d, 32'h0F);
    chk("R8 irq overrun masked only", {31'h0, irq}, 32'h0);
    xfer(8'h20, 8'hA0);
    xfer(8'h21, 8'hA1);
    rreg(4'h2, d); chk("R10 overrun bits", d, 32'h3F);
    chk("R8 R10 irq from overrun", {31'h0, irq}, 32'h1);
    wreg(4'h2, 32'h3F);
    rreg(4'h2, d); chk("R9 clear all", d, 32'h0);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    xfer(8'h30, 8'hB0);
    xfer(8'h31, 8'hB1);
    rreg(4'h2, d); chk("R4 end only", d, 32'h0A);
    xfer(8'h32, 8'hB2);
    @(negedge clk);
    frame_stb = 1'b1; rx_b1 = 8'h33; rx_b2 = 8'hB3;
    @(negedge clk);
    frame_stb = 1'b0;
    reg_we = 1'b1; reg_addr = 4'h2; reg_wdata = 32'h01;
    @(negedge clk);
    reg_we = 1'b0;
    chk("R6 rx word at mid", rx_mem[rx_p[7:0]], 32'h0000B333);
    tx_p = step(tx_p, 16'h10, 16'h13);
    rx_p = step(rx_p, 16'h40, 16'h43);
    rreg(4'h2, d); chk("R9 set wins over clear", d, 32'h0F);
    wreg(4'h2, 32'h3F);
  endtask

  task automatic t_disable;
    logic [31:0] d;
    logic [7:0] b1_before;
    wreg(4'h0, 32'h0);
    rreg(4'h6, d); chk("R7 tx reload", d, 32'h10);
    rreg(4'hA, d); chk("R7 rx reload", d, 32'h40);
    b1_before = tx_b1;
    @(negedge clk); frame_stb = 1'b1;
    @(negedge clk); frame_stb = 1'b0;
    chk("R7 no rd_req", {31'h0, rd_req}, 32'h0);
    chk("R7 no wr_req", {31'h0, wr_req}, 32'h0);
    @(negedge clk);
    chk("R7 lane unchanged", {24'h0, tx_b1}, {24'h0, b1_before});
    rreg(4'h6, d); chk("R7 cur held", d, 32'h10);
    tx_p = 16'h10; rx_p = 16'h40;
  endtask

  task automatic t_stall;
    logic [31:0] d;
    wreg(4'h0, 32'h1);
    stall = 1'b1;
    @(negedge clk); frame_stb = 1'b1; rx_b1 = 8'h11; rx_b2 = 8'h22;
    @(negedge clk); frame_stb = 1'b0;
    repeat (2) @(negedge clk);
    frame_stb = 1'b1; rx_b1 = 8'h33; rx_b2 = 8'h44;
    @(negedge clk); frame_stb = 1'b0;
    chk("R11 req held", {31'h0, rd_req}, 32'h1);
    chk("R11 addr held", {16'h0, rd_addr}, 32'h10);
    stall = 1'b0;
    @(negedge clk);
    chk("R11 one transfer", {31'h0, rd_req}, 32'h0);
    chk("R6 first bytes kept", rx_mem[8'h40], 32'h00002211);
    repeat (2) @(negedge clk);
    rreg(4'h6, d); chk("R11 strobe while busy ignored", d, 32'h11);
    tx_p = 16'h11; rx_p = 16'h41;
    xfer(8'h55, 8'h66);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    frame_stb = 1'b0; rx_b1 = '0; rx_b2 = '0; stall = 1'b0;
    tx_p = 16'h10; rx_p = 16'h40;
    for (int i = 0; i < 256; i++) rx_mem[i] = 32'hDEADBEEF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_program;
    t_halves;
    t_irq;
    t_overrun;
    t_set_wins;
    t_disable;
    t_stall;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule